// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Next-PC Unit

This unit chooses the fetch address for a five-stage in-order pipeline. Conditional branches, direct jumps and register-indirect jumps are resolved while the control-transfer instruction is in decode. The zero test on the branch operand and the target adders sit in that stage, so fetch moves to the correct path in the cycle after decode. A taken transfer therefore costs at most one fetch slot.

A parameter picks how that slot is handled. With `DELAY_SLOT = 0` the unit predicts not-taken. The sequential successor is already being fetched, so `squash_o` tells the fetch/decode register to turn it into a bubble. The unit also remembers that the next decode occupant is dead and ignores it. With `DELAY_SLOT = 1` the instruction after a transfer always executes and the redirect lands right behind it.

The unit owns the fetch PC register. It also drives the return address that linking jumps hand to the register-write path.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals `START_PC` (default 0x0000_1000) and `squash_o` is low, so no squash is pending after reset.
- R2: With no stall and no taken transfer in decode, `pc_o` advances by 4 at each rising clock, and `next_pc_o` shows `pc_o + 4` in the cycle before.
- R3: Opcode field bits 31:26 = 0x04 is a branch taken when `rs_val_i` is zero, and 0x05 is a branch taken when `rs_val_i` is nonzero. The taken target is `id_pc_i + 4 + (sign-extended bits 15:0 << 2)`, and `pc_o` holds it one clock after decode.
- R4: An untaken branch changes nothing: the PC advances by 4, `squash_o` stays low and `link_o` stays low.
- R5: Opcodes 0x02 (jump) and 0x03 (jump and link) are always taken. Their target is bits 31:28 of `id_pc_i + 4`, followed by bits 25:0 of the instruction, followed by two zero bits.
- R6: Opcodes 0x12 (register jump) and 0x13 (register jump and link) are always taken. Their target is `rs_val_i` with bits 1:0 forced to zero.
- R7: For opcodes 0x03 and 0x13, when the decode instruction is acted on, `link_o` is high and `link_addr_o` is `id_pc_i + 4` in predict mode or `id_pc_i + 8` in delay-slot mode. All other opcodes leave `link_o` low.
- R8: In predict mode, `squash_o` is high exactly in the cycles where decode holds a taken transfer that is acted on.
- R9: In delay-slot mode, `squash_o` never rises. The instruction fetched after a transfer reaches decode and is acted on like any other.
- R10: In predict mode, the instruction in decode in the cycle after a squash is ignored. It causes no redirect, no squash and no link, even when it is a taken transfer.
- R11: While `stall_i` is high, `pc_o` holds its value, `next_pc_o` equals `pc_o`, and `squash_o` and `link_o` are low.
- R12: A squash that is pending when a stall starts stays pending: the dead decode occupant is still ignored once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze fetch PC and decode decision |
| id_insn_i | input | 32 | Instruction word in decode |
| id_pc_i | input | XLEN | Address of the decode instruction |
| rs_val_i | input | XLEN | First register operand, used for the zero test and register jumps |
| pc_o | output | XLEN | Current fetch address |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| squash_o | output | 1 | Turn the instruction now in fetch into a bubble |
| link_o | output | 1 | Decode instruction writes a return address |
| link_addr_o | output | XLEN | Return address to write |

## Verification
The assertions check four things every cycle: the PC freezes under stall, a stall never coincides with a squash or a link, two squashes never come back to back, and delay-slot mode never squashes. The bench scenarios are needed for the rest. They show that each transfer kind lands on the right target. They show that the zero test picks the right direction for both polarities and signed offsets. They show that the slot after a squash is ignored even when it holds a taken branch, and that this stays true across a stall. They also show that the return address depends on the mode.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned INSN_W = 32;

  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_JMPL  = 6'h03;
  localparam logic [5:0] OPC_BRZ   = 6'h04;
  localparam logic [5:0] OPC_BRNZ  = 6'h05;
  localparam logic [5:0] OPC_JREG  = 6'h12;
  localparam logic [5:0] OPC_JREGL = 6'h13;

  typedef enum logic [2:0] {
    XFER_NONE,
    XFER_BR_Z,
    XFER_BR_NZ,
    XFER_DIRECT,
    XFER_INDIRECT
  } xfer_e;

  typedef struct packed {
    xfer_e kind;
    logic  link;
  } xfer_ctl_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output xfer_ctl_t         ctl_o,
  output logic [15:0]       imm_o,
  output logic [25:0]       idx_o
);

  logic [5:0] opc;

  assign opc   = insn_i[31:26];
  assign imm_o = insn_i[15:0];
  assign idx_o = insn_i[25:0];

  always_comb begin
    ctl_o = '{kind: XFER_NONE, link: 1'b0};
    unique case (opc)
      OPC_BRZ:   ctl_o.kind = XFER_BR_Z;
      OPC_BRNZ:  ctl_o.kind = XFER_BR_NZ;
      OPC_JMP:   ctl_o.kind = XFER_DIRECT;
      OPC_JMPL:  ctl_o = '{kind: XFER_DIRECT, link: 1'b1};
      OPC_JREG:  ctl_o.kind = XFER_INDIRECT;
      OPC_JREGL: ctl_o = '{kind: XFER_INDIRECT, link: 1'b1};
      default:   ctl_o = '{kind: XFER_NONE, link: 1'b0};
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] id_pc_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  xfer_ctl_t       ctl_i,
  input  logic [15:0]     imm_i,
  input  logic [25:0]     idx_i,
  output logic            taken_o,
  output logic [XLEN-1:0] tgt_o
);

  localparam int unsigned SEXT_W = XLEN - 18;
  localparam int unsigned REGN_W = XLEN - 28;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] reg_tgt;
  logic            rs_zero;

  assign seq_pc  = id_pc_i + XLEN'(4);
  assign br_tgt  = seq_pc + {{SEXT_W{imm_i[15]}}, imm_i, 2'b00};
  assign jmp_tgt = {seq_pc[XLEN-1 -: REGN_W], idx_i, 2'b00};
  assign reg_tgt = {rs_val_i[XLEN-1:2], 2'b00};
  assign rs_zero = (rs_val_i == '0);

  always_comb begin
    taken_o = 1'b0;
    tgt_o   = br_tgt;
    unique case (ctl_i.kind)
      XFER_BR_Z:     taken_o = rs_zero;
      XFER_BR_NZ:    taken_o = !rs_zero;
      XFER_DIRECT:   begin taken_o = 1'b1; tgt_o = jmp_tgt; end
      XFER_INDIRECT: begin taken_o = 1'b1; tgt_o = reg_tgt; end
      default:       taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] START_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [XLEN-1:0] tgt_i,
  input  logic            squash_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            kill_o
);

  logic [XLEN-1:0] pc_q;
  logic            kill_q;

  always_comb begin
    if (stall_i)         next_pc_o = pc_q;
    else if (redirect_i) next_pc_o = tgt_i;
    else                 next_pc_o = pc_q + XLEN'(4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= START_PC;
      kill_q <= 1'b0;
    end else if (!stall_i) begin
      pc_q   <= next_pc_o;
      kill_q <= squash_i;   // decode occupant next cycle is the squashed one
    end
  end

  assign pc_o   = pc_q;
  assign kill_o = kill_q;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] START_PC   = 32'h0000_1000,
  parameter bit              DELAY_SLOT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [INSN_W-1:0] id_insn_i,
  input  logic [XLEN-1:0]   id_pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              squash_o,
  output logic              link_o,
  output logic [XLEN-1:0]   link_addr_o
);

  xfer_ctl_t       ctl;
  logic [15:0]     imm;
  logic [25:0]     idx;
  logic            taken;
  logic [XLEN-1:0] tgt;
  logic            kill;
  logic            act;
  logic            redirect;

  npc_decode i_decode (
    .insn_i (id_insn_i),
    .ctl_o  (ctl),
    .imm_o  (imm),
    .idx_o  (idx)
  );

  npc_target #(.XLEN(XLEN)) i_target (
    .id_pc_i  (id_pc_i),
    .rs_val_i (rs_val_i),
    .ctl_i    (ctl),
    .imm_i    (imm),
    .idx_i    (idx),
    .taken_o  (taken),
    .tgt_o    (tgt)
  );

  assign act      = !stall_i && !kill;
  assign redirect = act && taken;
  assign link_o   = act && ctl.link;

  generate
    if (DELAY_SLOT) begin : g_delay
      assign squash_o    = 1'b0;
      assign link_addr_o = id_pc_i + XLEN'(8);  // skip the slot
    end else begin : g_predict
      assign squash_o    = redirect;
      assign link_addr_o = id_pc_i + XLEN'(4);
    end
  endgenerate

  npc_pc_reg #(.XLEN(XLEN), .START_PC(START_PC)) i_pc_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .redirect_i (redirect),
    .tgt_i      (tgt),
    .squash_i   (squash_o),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .kill_o     (kill)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int unsigned XLEN       = 32,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic [XLEN-1:0] pc_o,
  input logic            squash_o,
  input logic            link_o
);

  a_r11_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> pc_o == $past(pc_o));

  a_r11_quiet_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> (!squash_o && !link_o));

  a_r10_no_double_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !squash_o);

  generate
    if (DELAY_SLOT) begin : g_ds
      a_r9_never_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !squash_o);
    end
  endgenerate

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .DELAY_SLOT(DELAY_SLOT)) i_npc_unit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stall_i  (stall_i),
  .pc_o     (pc_o),
  .squash_o (squash_o),
  .link_o   (link_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] START      = 32'h0000_1000;
  localparam logic [5:0]  O_J = 6'h02, O_JL = 6'h03, O_BZ = 6'h04, O_BNZ = 6'h05,
                          O_JR = 6'h12, O_JRL = 6'h13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] id_insn = '0;
  logic [31:0] id_pc = '0;
  logic [31:0] rs_val = '0;

  logic [31:0] pc_w [2];
  logic [31:0] npc_w [2];
  logic        sq_w [2];
  logic        lk_w [2];
  logic [31:0] la_w [2];

  logic [31:0] m_pc [2];
  logic        m_kill [2];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit #(.START_PC(START), .DELAY_SLOT(1'b0)) i_npc_unit (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .id_insn_i(id_insn),
    .id_pc_i(id_pc), .rs_val_i(rs_val), .pc_o(pc_w[0]), .next_pc_o(npc_w[0]),
    .squash_o(sq_w[0]), .link_o(lk_w[0]), .link_addr_o(la_w[0]));

  npc_unit #(.START_PC(START), .DELAY_SLOT(1'b1)) i_npc_unit_dly (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .id_insn_i(id_insn),
    .id_pc_i(id_pc), .rs_val_i(rs_val), .pc_o(pc_w[1]), .next_pc_o(npc_w[1]),
    .squash_o(sq_w[1]), .link_o(lk_w[1]), .link_addr_o(la_w[1]));

  function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] rs, logic [15:0] imm);
    return {op, rs, 5'd0, imm};
  endfunction

  function automatic logic [31:0] mk_j(logic [5:0] op, logic [25:0] idx);
    return {op, idx};
  endfunction

  task automatic chk(string tag, string what, int m, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s mode%0d: got %h expected %h", tag, what, m, act, exp);
    end
  endtask

  task automatic step(logic [31:0] insn, logic [31:0] rs, logic [31:0] ipc,
                      logic stl, string tag);
    logic [31:0] nxt_pc [2];
    logic        nxt_kill [2];
    id_insn = insn; rs_val = rs; id_pc = ipc; stall = stl;
    #1;
    for (int m = 0; m < 2; m++) begin
      logic        tk, lk, act, sq;
      logic [31:0] tgt, npc, seq;
      seq = ipc + 32'd4;
      tk = 1'b0; lk = 1'b0; tgt = '0;
      case (insn[31:26])
        O_BZ:  begin tk = (rs == 0); tgt = seq + {{14{insn[15]}}, insn[15:0], 2'b00}; end
        O_BNZ: begin tk = (rs != 0); tgt = seq + {{14{insn[15]}}, insn[15:0], 2'b00}; end
        O_J:   begin tk = 1'b1; tgt = {seq[31:28], insn[25:0], 2'b00}; end
        O_JL:  begin tk = 1'b1; lk = 1'b1; tgt = {seq[31:28], insn[25:0], 2'b00}; end
        O_JR:  begin tk = 1'b1; tgt = rs & ~32'd3; end
        O_JRL: begin tk = 1'b1; lk = 1'b1; tgt = rs & ~32'd3; end
        default: ;
      endcase
      act = !stl && !m_kill[m];
      sq  = (m == 0) && act && tk;
      npc = stl ? m_pc[m] : (act && tk) ? tgt : m_pc[m] + 32'd4;
      chk(tag, "pc", m, pc_w[m], m_pc[m]);
      chk(tag, "next_pc", m, npc_w[m], npc);
      chk(m == 0 ? "R8" : "R9", "squash", m, {31'd0, sq_w[m]}, {31'd0, sq});
      chk("R7", "link", m, {31'd0, lk_w[m]}, {31'd0, act && lk});
      if (act && lk) chk("R7", "link_addr", m, la_w[m], ipc + (m == 0 ? 32'd4 : 32'd8));
      nxt_pc[m]   = npc;
      nxt_kill[m] = stl ? m_kill[m] : sq;
    end
    @(posedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      m_pc[m]   = nxt_pc[m];
      m_kill[m] = nxt_kill[m];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin m_pc[m] = START; m_kill[m] = 1'b0; end
    #(CLK_PERIOD * 2 + 1);
    for (int m = 0; m < 2; m++) begin
      chk("R1", "reset pc", m, pc_w[m], START);
      chk("R1", "reset squash", m, {31'd0, sq_w[m]}, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 sequential flow
    step('0, 32'd5, 32'h0000_0ffc, 1'b0, "R2");
    step('0, 32'd0, 32'h0000_1000, 1'b0, "R2");
    step('0, 32'd0, 32'h0000_1004, 1'b0, "R2");
    // R3 taken on zero, forward offset
    step(mk_i(O_BZ, 5'd3, 16'h0010), 32'd0, 32'h0000_1008, 1'b0, "R3");
    // R10 slot after squash holds a taken jump: ignored in predict mode
    step(mk_j(O_J, 26'h0000_400), 32'd0, 32'h0000_100c, 1'b0, "R10");
    step('0, 32'd0, 32'h0000_104c, 1'b0, "R2");
    // R4 untaken in both polarities
    step(mk_i(O_BZ, 5'd1, 16'h0040), 32'd7, 32'h0000_1050, 1'b0, "R4");
    step(mk_i(O_BNZ, 5'd1, 16'h0040), 32'd0, 32'h0000_1054, 1'b0, "R4");
    // R3 taken on nonzero, backward offset
    step(mk_i(O_BNZ, 5'd2, 16'hfff8), 32'h8000_0000, 32'h0000_1058, 1'b0, "R3");
    step('0, 32'd0, 32'h0000_105c, 1'b0, "R2");
    // R5 direct jump keeps region bits
    step(mk_j(O_J, 26'h3ff_ffff), 32'd0, 32'hafff_fffc, 1'b0, "R5");
    step('0, 32'd0, 32'h0000_0000, 1'b0, "R2");
    step(mk_j(O_JL, 26'h012_3456), 32'd0, 32'h5000_0200, 1'b0, "R5");
    step('0, 32'd0, 32'h5000_0204, 1'b0, "R2");
    // R6 register jumps clear low bits
    step(mk_i(O_JR, 5'd9, 16'h0), 32'h0000_2223, 32'h0000_3000, 1'b0, "R6");
    step('0, 32'd0, 32'h0000_3004, 1'b0, "R2");
    step(mk_i(O_JRL, 5'd9, 16'h0), 32'h0000_4006, 32'h0000_3100, 1'b0, "R6");
    step('0, 32'd0, 32'h0000_3104, 1'b0, "R2");
    // R11 stall holds a pending branch, then it resolves
    step(mk_i(O_BZ, 5'd4, 16'h0100), 32'd0, 32'h0000_3200, 1'b1, "R11");
    step(mk_i(O_BZ, 5'd4, 16'h0100), 32'd0, 32'h0000_3200, 1'b1, "R11");
    step(mk_i(O_BZ, 5'd4, 16'h0100), 32'd0, 32'h0000_3200, 1'b0, "R3");
    // R12 stall right after a squash; dead slot still ignored afterwards
    step(mk_i(O_JRL, 5'd4, 16'h0), 32'h0000_7000, 32'h0000_3204, 1'b1, "R12");
    step(mk_i(O_JRL, 5'd4, 16'h0), 32'h0000_7000, 32'h0000_3204, 1'b0, "R12");
    step('0, 32'd0, 32'h0000_3608, 1'b0, "R2");
    // R9 back-to-back transfers: second acts only in delay-slot mode
    step(mk_i(O_BNZ, 5'd1, 16'h0002), 32'd1, 32'h0000_4000, 1'b0, "R9");
    step(mk_i(O_BZ, 5'd1, 16'h0004), 32'd0, 32'h0000_4004, 1'b0, "R9");
    step('0, 32'd0, 32'h0000_4018, 1'b0, "R2");
    step('0, 32'd0, 32'h0000_401c, 1'b0, "R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule